// File: doc/BRIEF.md
# Auto-Negotiation Progress Latch Monitor

This block sits beside an Ethernet auto-negotiation arbitration state machine. It keeps a 4-bit record of the furthest point that negotiation has reached, so that a management entity can find out why a link failed to come up. The record is a high-water mark and not a copy of the current state. A new arbitration state code replaces the stored code only when it is legal and strictly larger. The stored code stops moving once negotiation reports completion, and it returns to zero after the management entity reads it.

Management access uses a plain read strobe with an address. Address 17 returns a packed detailed-status word that holds the progress code together with the link, rate and duplex flags. Address 0 returns the control bits that the block owns. A management read of address 17 clears the progress code.

Negotiation is restarted by any of four events: a self-clearing restart bit in a control write, the enable control bit dropping and then returning to 1, the select pin dropping and then returning to 1, or a link failure. A restart zeroes the stored code and sends a one-cycle restart pulse to the arbitration state machine.

Top module: `an_progress_mon`

## Requirements
- R1: While `rd_addr` is 17, `rd_data` shows the detailed-status word. Bit 15 is `rate_hi`, bit 14 is `full_dup`, bits 13:11 are progress code bits 2:0, bit 4 is progress code bit 3, and bit 0 is `link_up`. Every other bit is 0. After reset the progress code is 0h.
- R2: Only codes 0h to 8h and Fh can be stored. Arbitration codes 9h to Eh never change the stored code.
- R3: A legal arbitration code is stored on the next clock only when it is strictly greater than the stored code. Equal or smaller codes leave the stored code unchanged.
- R4: While `an_done` is 1, no arbitration code is stored.
- R5: A read strobe at address 17 returns the stored code in the same cycle and clears the code to 0h at the next clock. If a storable code arrives in the same cycle as the read, that code is loaded instead of 0h.
- R6: A control write with bit 9 set causes a restart. At the next clock the progress code becomes 0h and `an_restart` is 1 for exactly one cycle. Control readback bit 9 is 1 in that cycle only.
- R7: A control write sets the enable flag from data bit 12 (reset value 1). The enable flag returning from 0 to 1 causes a restart, and the restart becomes visible two clocks after the write that sets it to 1. Clearing the enable flag alone causes no restart.
- R8: `sel_pin` is synchronised through two flops. A return from 0 to 1 causes a restart three clocks after the pin rises. A fall alone causes no restart.
- R9: A rising edge on `link_fail` causes a restart at the next clock.
- R10: Address 0 returns the enable flag in bit 12 and the restart pulse in bit 9, with every other bit 0. Any address other than 0 and 17 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arb_state | input | 4 | Current arbitration state code |
| an_done | input | 1 | Negotiation complete flag |
| link_up | input | 1 | Link status |
| rate_hi | input | 1 | Data rate flag (1 = high rate) |
| full_dup | input | 1 | Duplex flag (1 = full) |
| link_fail | input | 1 | Link failure indication |
| sel_pin | input | 1 | Asynchronous negotiation select pin |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata | input | 16 | Control write data |
| rd_stb | input | 1 | Management read strobe |
| rd_addr | input | 5 | Management read address |
| rd_data | output | 16 | Management read data |
| an_restart | output | 1 | One-cycle restart pulse |

## Verification
The assertions check on every cycle that the stored code is always legal, that it never falls except after a restart or a read, that it holds still while completion is flagged, that a read clears it, and that every restart event produces exactly one pulse and a zeroed code. Some behaviour is shown only by the bench scenarios: the exact packing of bits in both read words, the three-clock delay of the pin path, the two-clock delay of the enable toggle, the fact that a fall alone on the pin or the enable flag does nothing, and the case where a code arrives in the same cycle as a read. The bench's behavioural model is compared with the read data and the restart pulse on every clock.

// File: rtl/an_prog_pkg.sv
package an_prog_pkg;
  localparam int CODE_W = 4;
  localparam int WORD_W = 16;
  localparam int ADDR_W = 5;
  localparam int CTL_RESTART_BIT = 9;
  localparam int CTL_ENABLE_BIT  = 12;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_STAT = ADDR_W'(17);
  localparam logic [CODE_W-1:0] CODE_TOP  = 4'hF;
  localparam logic [CODE_W-1:0] CODE_LAST_LOW = 4'h8;

  function automatic logic code_legal(input logic [CODE_W-1:0] c);
    return (c <= CODE_LAST_LOW) || (c == CODE_TOP);
  endfunction

  function automatic logic [WORD_W-1:0] pack_status(input logic rate, input logic dup,
                                                    input logic link,
                                                    input logic [CODE_W-1:0] code);
    logic [WORD_W-1:0] w;
    w = '0;
    w[15] = rate;
    w[14] = dup;
    w[13:11] = code[2:0];
    w[4] = code[3];
    w[0] = link;
    return w;
  endfunction

  function automatic logic [WORD_W-1:0] pack_ctrl(input logic en, input logic rst);
    logic [WORD_W-1:0] w;
    w = '0;
    w[CTL_ENABLE_BIT]  = en;
    w[CTL_RESTART_BIT] = rst;
    return w;
  endfunction
endpackage

// File: rtl/an_restart_src.sv
module an_restart_src
  import an_prog_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_restart,
  input  logic wr_enable,
  input  logic wr_en_val,
  input  logic sel_pin,
  input  logic link_fail,
  output logic en_q,
  output logic restart_evt,
  output logic restart_q
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic pin_prev, en_prev, lf_prev;
  logic ev_wr, ev_en, ev_pin, ev_lf;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q   <= '1;
      pin_prev <= 1'b1;
      en_q     <= 1'b1;
      en_prev  <= 1'b1;
      lf_prev  <= 1'b0;
      restart_q <= 1'b0;
    end else begin
      sync_q   <= {sync_q[SYNC_STAGES-2:0], sel_pin};
      pin_prev <= sync_q[LAST];
      if (wr_enable) en_q <= wr_en_val;
      en_prev  <= en_q;
      lf_prev  <= link_fail;
      restart_q <= restart_evt;
    end
  end

  assign ev_wr  = wr_restart;
  assign ev_en  = en_q & ~en_prev;
  assign ev_pin = sync_q[LAST] & ~pin_prev;
  assign ev_lf  = link_fail & ~lf_prev;
  assign restart_evt = ev_wr | ev_en | ev_pin | ev_lf;

  AST_RESTART_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    restart_evt |=> restart_q); // R6
  AST_RESTART_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    !restart_evt |=> !restart_q); // R6
  AST_LINK_FAIL_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (link_fail && !lf_prev) |=> restart_q); // R9
endmodule

// File: rtl/an_progress_hold.sv
module an_progress_hold
  import an_prog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] arb_state,
  input  logic              an_done,
  input  logic              restart_evt,
  input  logic              rd_clr,
  output logic [CODE_W-1:0] prog_q,
  output logic              latch_hit
);
  assign latch_hit = code_legal(arb_state) && (arb_state > prog_q) && !an_done;

  always_ff @(posedge clk) begin
    if (!rst_n)           prog_q <= '0;
    else if (restart_evt) prog_q <= '0;
    else if (latch_hit)   prog_q <= arb_state;
    else if (rd_clr)      prog_q <= '0;
  end

  AST_LEGAL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    code_legal(prog_q)); // R2
  AST_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart_evt && !rd_clr) |=> (prog_q >= $past(prog_q))); // R3
  AST_DONE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (an_done && !restart_evt && !rd_clr) |=> $stable(prog_q)); // R4
  AST_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !restart_evt && !latch_hit) |=> (prog_q == '0)); // R5
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    restart_evt |=> (prog_q == '0)); // R6
endmodule

// File: rtl/an_status_read.sv
module an_status_read
  import an_prog_pkg::*;
(
  input  logic              rd_stb,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [CODE_W-1:0] prog,
  input  logic              rate_hi,
  input  logic              full_dup,
  input  logic              link_up,
  input  logic              en_q,
  input  logic              restart_q,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_clr
);
  always_comb begin
    unique case (rd_addr)
      ADDR_STAT: rd_data = pack_status(rate_hi, full_dup, link_up, prog);
      ADDR_CTRL: rd_data = pack_ctrl(en_q, restart_q);
      default:   rd_data = '0;
    endcase
  end

  assign rd_clr = rd_stb && (rd_addr == ADDR_STAT);
endmodule

// File: rtl/an_progress_mon.sv
module an_progress_mon
  import an_prog_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  arb_state,
  input  logic        an_done,
  input  logic        link_up,
  input  logic        rate_hi,
  input  logic        full_dup,
  input  logic        link_fail,
  input  logic        sel_pin,
  input  logic        ctl_wr,
  input  logic [15:0] ctl_wdata,
  input  logic        rd_stb,
  input  logic [4:0]  rd_addr,
  output logic [15:0] rd_data,
  output logic        an_restart
);
  logic              en_q, restart_evt, restart_q, rd_clr, latch_hit;
  logic [CODE_W-1:0] prog_q;

  an_restart_src #(.SYNC_STAGES(2)) u_src (
    .clk(clk), .rst_n(rst_n),
    .wr_restart(ctl_wr & ctl_wdata[CTL_RESTART_BIT]),
    .wr_enable(ctl_wr), .wr_en_val(ctl_wdata[CTL_ENABLE_BIT]),
    .sel_pin(sel_pin), .link_fail(link_fail),
    .en_q(en_q), .restart_evt(restart_evt), .restart_q(restart_q)
  );

  an_progress_hold u_hold (
    .clk(clk), .rst_n(rst_n), .arb_state(arb_state), .an_done(an_done),
    .restart_evt(restart_evt), .rd_clr(rd_clr),
    .prog_q(prog_q), .latch_hit(latch_hit)
  );

  an_status_read u_rd (
    .rd_stb(rd_stb), .rd_addr(rd_addr), .prog(prog_q),
    .rate_hi(rate_hi), .full_dup(full_dup), .link_up(link_up),
    .en_q(en_q), .restart_q(restart_q),
    .rd_data(rd_data), .rd_clr(rd_clr)
  );

  assign an_restart = restart_q;

  AST_UNUSED_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr != ADDR_CTRL && rd_addr != ADDR_STAT) |-> (rd_data == '0)); // R10
  AST_LATCH_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_hit && !restart_evt) |=> (prog_q == $past(arb_state))); // R3
endmodule

// File: tb/sim_an_progress_mon.sv
`timescale 1ns/1ps
module sim_an_progress_mon;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] arb_state = 4'h0;
  logic an_done = 0, link_up = 0, rate_hi = 0, full_dup = 0, link_fail = 0;
  logic sel_pin = 1'b1, ctl_wr = 0, rd_stb = 0;
  logic [15:0] ctl_wdata = 16'h0;
  logic [4:0]  rd_addr = 5'd17;
  logic [15:0] rd_data;
  logic        an_restart;

  int checks = 0, errors = 0;
  bit done = 0;
  string cur_req = "R1";

  // behavioural reference state
  int m_prog, m_rst, m_en, m_en_prev, m_lf_prev;
  int pin_hist[$];

  always #2.5 clk = ~clk;

  an_progress_mon u0 (
    .clk(clk), .rst_n(rst_n), .arb_state(arb_state), .an_done(an_done),
    .link_up(link_up), .rate_hi(rate_hi), .full_dup(full_dup),
    .link_fail(link_fail), .sel_pin(sel_pin), .ctl_wr(ctl_wr),
    .ctl_wdata(ctl_wdata), .rd_stb(rd_stb), .rd_addr(rd_addr),
    .rd_data(rd_data), .an_restart(an_restart)
  );

  function automatic int storable(int c);
    return (c >= 0 && c <= 8) || c == 15;
  endfunction

  function automatic int expect_rd();
    if (rd_addr == 17)
      return rate_hi * 32768 + full_dup * 16384 + (m_prog % 8) * 2048
             + (m_prog / 8) * 16 + link_up;
    if (rd_addr == 0)
      return m_en * 4096 + m_rst * 512;
    return 0;
  endfunction

  task automatic model_reset();
    m_prog = 0; m_rst = 0; m_en = 1; m_en_prev = 1; m_lf_prev = 0;
    pin_hist = '{1, 1, 1};
  endtask

  task automatic model_clock();
    int restart, latch, rdclr, pin_rise, nxt;
    // pin_hist[0] is the newest sample; rise seen after two sync stages
    pin_rise = (pin_hist[1] == 1) && (pin_hist[2] == 0);
    restart = (ctl_wr && ctl_wdata[9]) || (m_en == 1 && m_en_prev == 0)
              || pin_rise || (link_fail && m_lf_prev == 0);
    latch = storable(int'(arb_state)) && int'(arb_state) > m_prog && !an_done;
    rdclr = rd_stb && rd_addr == 17;
    nxt = restart ? 0 : latch ? int'(arb_state) : rdclr ? 0 : m_prog;
    m_prog = nxt;
    m_rst = restart;
    m_en_prev = m_en;
    if (ctl_wr) m_en = ctl_wdata[12];
    m_lf_prev = link_fail;
    pin_hist.push_front(int'(sel_pin));
    void'(pin_hist.pop_back());
  endtask

  task automatic check(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  task automatic step();
    #1;
    check("rd_data", int'(rd_data), expect_rd());
    check("an_restart", int'(an_restart), m_rst);
    @(posedge clk);
    model_clock();
    @(negedge clk);
  endtask

  task automatic quiet();
    ctl_wr = 0; ctl_wdata = 16'h1000; rd_stb = 0; link_fail = 0; rd_addr = 5'd17;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R1: reset state and packing of the status word
    cur_req = "R1";
    step();
    rate_hi = 1; full_dup = 1; link_up = 1; arb_state = 4'h2;
    step(); step();
    rate_hi = 0; step();
    // R3: strictly greater only
    cur_req = "R3";
    arb_state = 4'h3; step();
    arb_state = 4'h1; step(); step();
    arb_state = 4'h3; step();
    arb_state = 4'h5; step(); step();
    // R2: illegal codes ignored, Fh stored
    cur_req = "R2";
    for (int c = 9; c <= 14; c++) begin arb_state = 4'(c); step(); end
    arb_state = 4'h8; step(); step();   // R1 bit 4 from code bit 3
    arb_state = 4'hF; step(); step();
    // R5: read returns then clears
    cur_req = "R5";
    arb_state = 4'h0;
    rd_stb = 1; step(); rd_stb = 0; step(); step();
    arb_state = 4'h4; step();
    arb_state = 4'h6; rd_stb = 1; step(); rd_stb = 0; step(); step();
    // R4: completion freezes
    cur_req = "R4";
    an_done = 1; arb_state = 4'h8; step(); step();
    arb_state = 4'hF; step(); step();
    an_done = 0; step(); step();
    // R6: self-clearing restart bit
    cur_req = "R6";
    rd_addr = 5'd0; step();
    ctl_wr = 1; ctl_wdata = 16'h1200; arb_state = 4'h0; step();
    quiet(); rd_addr = 5'd0; step(); step(); rd_addr = 5'd17; step();
    // R7: enable toggle
    cur_req = "R7";
    arb_state = 4'h7; step();
    ctl_wr = 1; ctl_wdata = 16'h0000; step();
    ctl_wr = 0; rd_addr = 5'd0; step(); step(); step();
    rd_addr = 5'd17; step();
    ctl_wr = 1; ctl_wdata = 16'h1000; step();
    quiet(); step(); step(); step();
    // R8: select pin toggle
    cur_req = "R8";
    arb_state = 4'h8; step();
    sel_pin = 0; repeat (5) step();
    sel_pin = 1; repeat (5) step();
    // R9: link failure edge
    cur_req = "R9";
    arb_state = 4'hF; step();
    link_fail = 1; step(); step(); step();
    link_fail = 0; step(); step();
    // R10: control word and unused addresses
    cur_req = "R10";
    rd_addr = 5'd0; step();
    rd_addr = 5'd5; step();
    rd_addr = 5'd31; rd_stb = 1; step();
    rd_stb = 0; rd_addr = 5'd17; step();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule